// File: doc/BRIEF.md
# Two-Channel Serial Interrupt Status and Mask Unit

This block gathers the interrupt sources of a two-channel serial controller into one status byte. For each channel these sources are transmitter ready, receiver ready or FIFO full, and break change. The counter and the input port add one source each. The CPU writes a mask byte. An active-low request line is pulled low whenever any unmasked status bit is set. The request is meant for an open-drain, wired-OR interrupt net.

Each status bit has its own clearing event, which comes from the CPU side of the controller. The events are:
- a write to that channel's transmit holding register;
- a read of that channel's receive buffer;
- a reset-break-change command for that channel;
- a stop-counter command;
- a read of the input-change register.

An interrupt acknowledge cycle is accepted on an input, but it clears nothing. Software must remove each cause through its own clearing event.

The asynchronous reset is released through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `dual_chan_irq_status`

## Requirements
- R1: The status bit positions are fixed. Channel A uses bits 0 (transmit ready), 1 (receive ready or FIFO full) and 2 (break change). Channel B uses bits 4, 5 and 6 for the same three sources. Bit 3 is counter ready and bit 7 is input port change.
- R2: A transmit-ready bit is set on the rising edge of that channel's transmit-ready input. It is cleared by a write to the same channel's holding register. When a write and a rising edge fall in the same cycle, the write wins.
- R3: A receive bit is set in every cycle in which its condition input is high. A read of that channel's receive buffer clears the bit only in a cycle where the condition is low.
- R4: A break-change bit is set by a break-change pulse. It is cleared only by the reset-break-change command of the same channel. When a pulse and the command fall in the same cycle, the pulse wins.
- R5: Bit 3 is set by a counter-ready pulse and cleared by the stop-counter command. When both fall in the same cycle, the pulse wins.
- R6: Bit 7 is set by an input-change pulse and cleared by a read of the input-change register. When both fall in the same cycle, the pulse wins.
- R7: A status bit with neither a set nor its own clearing event in a cycle keeps its value. Clearing events of the other channel or of other sources have no effect on it.
- R8: The interrupt acknowledge input changes no status bit.
- R9: The mask byte loads the write data in the cycle after a write strobe, holds its value otherwise, and can be read at any time.
- R10: `irq_n_o` is low exactly when the bitwise AND of status and mask is nonzero, and it follows both without extra delay.
- R11: After reset, status and mask are zero and `irq_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_ready_i | input | 2 | Transmitter ready level, per channel (bit 0 = A) |
| rx_avail_i | input | 2 | Receive ready or FIFO full level, per channel |
| brk_delta_i | input | 2 | Break change pulse, per channel |
| ctr_ready_i | input | 1 | Counter ready pulse |
| inport_delta_i | input | 1 | Input port change pulse |
| thr_write_i | input | 2 | Transmit holding register write, per channel |
| rxbuf_read_i | input | 2 | Receive buffer read, per channel |
| brk_ack_cmd_i | input | 2 | Reset-break-change command, per channel |
| ctr_stop_cmd_i | input | 1 | Stop-counter command |
| inport_read_i | input | 1 | Input-change register read |
| iack_i | input | 1 | Interrupt acknowledge cycle (no clearing effect) |
| mask_we_i | input | 1 | Mask byte write strobe |
| mask_wdata_i | input | 8 | Mask byte write data |
| status_o | output | 8 | Status byte |
| mask_o | output | 8 | Mask byte |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions check, on every cycle, the local rules of each status bit:
- a transmit-ready bit is cleared by its write, even when a new edge arrives in the same cycle;
- a hold-type bit is set by its source;
- a bit with no event keeps its value;
- the mask register loads and holds as written;
- a cycle with an acknowledge and no clearing event lowers no status bit;
- a zero mask write releases the request.

Only the bench scenarios can show the rest. These are that each source lands on its own bit position, that clearing events for the other channel leave a bit alone, and that a receive read is ignored while the condition is high. They also show that the request matches status AND mask across all 256 mask values, and that the whole block stays in line with an arithmetic model over a long pseudo-random run.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int STAT_W    = 8;
  localparam int CH_N      = 2;
  localparam int CH_STRIDE = STAT_W / CH_N;
  localparam int OFS_TX    = 0;
  localparam int OFS_RX    = 1;
  localparam int OFS_BRK   = 2;
  localparam int POS_CTR   = 3;
  localparam int POS_INP   = 7;

  // KIND_HOLD: source level sets, set wins over clear.
  // KIND_EDGE: rising source edge sets, clear wins over set.
  typedef enum logic {KIND_HOLD, KIND_EDGE} kind_e;

  function automatic kind_e kind_of(input int idx);
    return ((idx % CH_STRIDE) == OFS_TX && idx != POS_CTR && idx != POS_INP)
           ? KIND_EDGE : KIND_HOLD;
  endfunction
endpackage

// File: rtl/isu_rst_sync.sv
module isu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/isu_status_bit.sv
module isu_status_bit
  import isu_pkg::*;
#(
  parameter kind_e KIND = KIND_HOLD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_nxt;
  logic set_ev;
  logic upd_en;

  generate
    if (KIND == KIND_EDGE) begin : g_edge
      logic src_d_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_d_q <= 1'b0;
        else        src_d_q <= src_i;
      end

      assign set_ev = src_i & ~src_d_q;

      always_comb begin
        q_nxt = clr_i ? 1'b0 : (q_q | set_ev);
      end

      // R2: a holding register write clears, even against a new edge
      assert_clear_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !q_o);
      assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && !clr_i) |=> q_o);
    end else begin : g_hold
      assign set_ev = src_i;

      always_comb begin
        q_nxt = set_ev | (q_q & ~clr_i);
      end

      // R3 (also R4, R5, R6): a source high in a cycle leaves the bit set
      assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        src_i |=> q_o);
      assert_clear_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !src_i) |=> !q_o);
    end
  endgenerate

  assign upd_en = set_ev | clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_q <= 1'b0;
    else if (upd_en) q_q <= q_nxt;
  end

  assign q_o = q_q;

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_ev && !clr_i) |=> (q_o == $past(q_o)));
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_nxt;

  always_comb begin
    mask_nxt = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (we_i) mask_q <= mask_nxt;
  end

  assign mask_o = mask_q;

  assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mask_o == $past(wdata_i)));
  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/isu_irq_gen.sv
module isu_irq_gen #(
  parameter int W = 8
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_n_o
);
  logic [W-1:0] active;

  always_comb begin
    active  = status_i & mask_i;
    irq_n_o = ~(|active);
  end
endmodule

// File: rtl/dual_chan_irq_status.sv
module dual_chan_irq_status
  import isu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH_N-1:0]   tx_ready_i,
  input  logic [CH_N-1:0]   rx_avail_i,
  input  logic [CH_N-1:0]   brk_delta_i,
  input  logic              ctr_ready_i,
  input  logic              inport_delta_i,
  input  logic [CH_N-1:0]   thr_write_i,
  input  logic [CH_N-1:0]   rxbuf_read_i,
  input  logic [CH_N-1:0]   brk_ack_cmd_i,
  input  logic              ctr_stop_cmd_i,
  input  logic              inport_read_i,
  input  logic              iack_i,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  output logic [STAT_W-1:0] status_o,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_n_o
);
  logic              srst_n;
  logic [STAT_W-1:0] src_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] stat_q;

  isu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Route sources and their clearing events onto the R1 bit positions.
  always_comb begin
    src_vec = '0;
    clr_vec = '0;
    for (int c = 0; c < CH_N; c++) begin
      src_vec[c*CH_STRIDE + OFS_TX]  = tx_ready_i[c];
      clr_vec[c*CH_STRIDE + OFS_TX]  = thr_write_i[c];
      src_vec[c*CH_STRIDE + OFS_RX]  = rx_avail_i[c];
      clr_vec[c*CH_STRIDE + OFS_RX]  = rxbuf_read_i[c];
      src_vec[c*CH_STRIDE + OFS_BRK] = brk_delta_i[c];
      clr_vec[c*CH_STRIDE + OFS_BRK] = brk_ack_cmd_i[c];
    end
    src_vec[POS_CTR] = ctr_ready_i;
    clr_vec[POS_CTR] = ctr_stop_cmd_i;
    src_vec[POS_INP] = inport_delta_i;
    clr_vec[POS_INP] = inport_read_i;
  end

  generate
    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      isu_status_bit #(.KIND(kind_of(i))) u_bit (
        .clk   (clk),
        .rst_n (srst_n),
        .src_i (src_vec[i]),
        .clr_i (clr_vec[i]),
        .q_o   (stat_q[i])
      );
    end
  endgenerate

  isu_mask_reg #(.W(STAT_W)) u_mask (
    .clk     (clk),
    .rst_n   (srst_n),
    .we_i    (mask_we_i),
    .wdata_i (mask_wdata_i),
    .mask_o  (mask_o)
  );

  isu_irq_gen #(.W(STAT_W)) u_irq (
    .status_i (stat_q),
    .mask_i   (mask_o),
    .irq_n_o  (irq_n_o)
  );

  assign status_o = stat_q;

  // R8: an acknowledge cycle without clearing events lowers no bit
  assert_iack_no_clear_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (iack_i && clr_vec == '0) |=> ((status_o & $past(status_o)) == $past(status_o)));
  // R10: a zero mask releases the request in the following cycle
  assert_zero_mask_release_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (mask_we_i && mask_wdata_i == '0) |=> irq_n_o);
endmodule

// File: tb/dual_chan_irq_status_tb.sv
module dual_chan_irq_status_tb_top;
  logic       clk;
  logic       rst_n;
  logic [1:0] tx_ready, rx_avail, brk_delta, thr_write, rxbuf_read, brk_ack;
  logic       ctr_ready, inport_delta, ctr_stop, inport_read, iack, mask_we;
  logic [7:0] mask_wdata;
  logic [7:0] status_o, mask_o;
  logic       irq_n_o;

  int total = 0;
  int bad   = 0;
  logic [7:0]  st_m, msk_m;
  logic [1:0]  ptx_m;
  logic [31:0] lfsr;

  dual_chan_irq_status dut_i (
    .clk(clk), .rst_n(rst_n),
    .tx_ready_i(tx_ready), .rx_avail_i(rx_avail), .brk_delta_i(brk_delta),
    .ctr_ready_i(ctr_ready), .inport_delta_i(inport_delta),
    .thr_write_i(thr_write), .rxbuf_read_i(rxbuf_read), .brk_ack_cmd_i(brk_ack),
    .ctr_stop_cmd_i(ctr_stop), .inport_read_i(inport_read), .iack_i(iack),
    .mask_we_i(mask_we), .mask_wdata_i(mask_wdata),
    .status_o(status_o), .mask_o(mask_o), .irq_n_o(irq_n_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic zero_inputs();
    tx_ready = '0; rx_avail = '0; brk_delta = '0; thr_write = '0;
    rxbuf_read = '0; brk_ack = '0; ctr_ready = 0; inport_delta = 0;
    ctr_stop = 0; inport_read = 0; iack = 0; mask_we = 0; mask_wdata = '0;
  endtask

  task automatic zero_events();
    brk_delta = '0; thr_write = '0; rxbuf_read = '0; brk_ack = '0;
    ctr_ready = 0; inport_delta = 0; ctr_stop = 0; inport_read = 0;
    iack = 0; mask_we = 0;
  endtask

  // Update the arithmetic model from the inputs, clock once, compare.
  task automatic step();
    logic [7:0] nx;
    nx = st_m;
    for (int c = 0; c < 2; c++) begin
      nx[4*c]   = thr_write[c] ? 1'b0 : ((tx_ready[c] & ~ptx_m[c]) | st_m[4*c]);
      nx[4*c+1] = rx_avail[c]  | (st_m[4*c+1] & ~rxbuf_read[c]);
      nx[4*c+2] = brk_delta[c] | (st_m[4*c+2] & ~brk_ack[c]);
    end
    nx[3] = ctr_ready    | (st_m[3] & ~ctr_stop);
    nx[7] = inport_delta | (st_m[7] & ~inport_read);
    st_m  = nx;
    ptx_m = tx_ready;
    if (mask_we) msk_m = mask_wdata;
    @(posedge clk);
    #2;
    chk("R7 model status", status_o, st_m);
    chk("R9 model mask", mask_o, msk_m);
    chk("R10 model irq", {7'd0, irq_n_o}, {7'd0, ((st_m & msk_m) == 8'h00)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    zero_inputs();
    st_m = '0; msk_m = '0; ptx_m = '0; lfsr = 32'h1D2C3B4A;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk("R11 status", status_o, 8'h00);
    chk("R11 mask", mask_o, 8'h00);
    chk("R11 irq_n", {7'd0, irq_n_o}, 8'h01);
    step();

    mask_we = 1; mask_wdata = 8'hFF; step(); zero_events();
    chk("R9 mask load", mask_o, 8'hFF);
    chk("R10 idle irq_n", {7'd0, irq_n_o}, 8'h01);

    // R2 / R1 channel A transmit
    tx_ready[0] = 1; step();
    chk("R2 tx A rise", status_o, 8'h01);
    chk("R10 irq low", {7'd0, irq_n_o}, 8'h00);
    step(); chk("R2 tx A held", status_o, 8'h01);
    thr_write[0] = 1; step(); zero_events();
    chk("R2 tx A write clears", status_o, 8'h00);
    tx_ready[0] = 0; step();
    tx_ready[0] = 1; thr_write[0] = 1; step(); zero_events();
    chk("R2 write beats edge", status_o, 8'h00);
    step(); chk("R2 no new edge", status_o, 8'h00);
    tx_ready[0] = 0; step();

    // R1 channel B transmit, other-channel write ignored
    tx_ready[1] = 1; step(); chk("R1 tx B bit4", status_o, 8'h10);
    thr_write[0] = 1; step(); zero_events();
    chk("R7 other write ignored", status_o, 8'h10);
    thr_write[1] = 1; step(); zero_events();
    chk("R2 tx B write clears", status_o, 8'h00);
    tx_ready[1] = 0; step();

    // R3 receive B
    rx_avail[1] = 1; step(); chk("R1 rx B bit5", status_o, 8'h20);
    rxbuf_read[1] = 1; step();
    chk("R3 read while cond high", status_o, 8'h20);
    rx_avail[1] = 0; step(); zero_events();
    chk("R3 read with cond low", status_o, 8'h00);

    // R3 receive A sticky
    rx_avail[0] = 1; step(); rx_avail[0] = 0; step();
    chk("R3 rx A sticky", status_o, 8'h02);
    rxbuf_read[1] = 1; step(); zero_events();
    chk("R7 other read ignored", status_o, 8'h02);
    rxbuf_read[0] = 1; step(); zero_events();
    chk("R3 rx A read clears", status_o, 8'h00);

    // R4 break change A
    brk_delta[0] = 1; step(); zero_events();
    chk("R4 brk A bit2", status_o, 8'h04);
    brk_ack[1] = 1; thr_write = 2'b11; rxbuf_read = 2'b11;
    ctr_stop = 1; inport_read = 1; step(); zero_events();
    chk("R4 only own command clears", status_o, 8'h04);
    brk_ack[0] = 1; step(); zero_events();
    chk("R4 own command clears", status_o, 8'h00);
    brk_delta[0] = 1; brk_ack[0] = 1; step(); zero_events();
    chk("R4 pulse beats command", status_o, 8'h04);
    brk_ack[0] = 1; step(); zero_events();
    brk_delta[1] = 1; step(); zero_events();
    chk("R1 brk B bit6", status_o, 8'h40);
    brk_ack[1] = 1; step(); zero_events();
    chk("R4 brk B cleared", status_o, 8'h00);

    // R5 counter, R6 input change
    ctr_ready = 1; step(); zero_events();
    chk("R5 counter bit3", status_o, 8'h08);
    ctr_stop = 1; step(); zero_events();
    chk("R5 stop clears", status_o, 8'h00);
    inport_delta = 1; step(); zero_events();
    chk("R6 inport bit7", status_o, 8'h80);
    inport_read = 1; step(); zero_events();
    chk("R6 read clears", status_o, 8'h00);

    // R8 acknowledge clears nothing
    tx_ready = 2'b11; rx_avail = 2'b11; brk_delta = 2'b11;
    ctr_ready = 1; inport_delta = 1; step(); zero_events();
    rx_avail = 2'b00; step();
    chk("R1 all set", status_o, 8'hFF);
    for (int k = 0; k < 3; k++) begin
      iack = 1; step();
      chk("R8 iack keeps status", status_o, 8'hFF);
    end
    iack = 0;

    // R10 / R9 exhaustive mask sweep with full status
    for (int m = 0; m < 256; m++) begin
      mask_we = 1; mask_wdata = m[7:0]; step(); mask_we = 0;
      chk("R9 mask sweep", mask_o, m[7:0]);
      chk("R10 mask sweep irq", {7'd0, irq_n_o}, {7'd0, (m == 0)});
    end

    // R10 one status bit against every single-bit mask
    thr_write = 2'b11; brk_ack = 2'b11; rxbuf_read = 2'b11;
    ctr_stop = 1; inport_read = 1; step(); zero_events();
    tx_ready = 2'b00; step();
    for (int b = 0; b < 8; b++) begin
      inport_delta = 1; step(); zero_events();
      mask_we = 1; mask_wdata = 8'h01 << b; step(); zero_events();
      chk("R10 single mask", {7'd0, irq_n_o}, {7'd0, (b != 7)});
      inport_read = 1; step(); zero_events();
    end

    // pseudo-random sweep against the model
    for (int n = 0; n < 3000; n++) begin
      for (int s = 0; s < 8; s++)
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      tx_ready = lfsr[1:0]; rx_avail = lfsr[3:2];
      brk_delta = lfsr[5:4] & lfsr[7:6];
      ctr_ready = lfsr[8] & lfsr[9]; inport_delta = lfsr[10] & lfsr[11];
      thr_write = lfsr[13:12]; rxbuf_read = lfsr[15:14]; brk_ack = lfsr[17:16];
      ctr_stop = lfsr[18]; inport_read = lfsr[19]; iack = lfsr[20];
      mask_we = lfsr[21] & lfsr[22]; mask_wdata = lfsr[30:23];
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule